// File: doc/BRIEF.md
# Card Supply Activation Supervisor

This block is the control state machine that runs one power session for a contact card. The host asks for a session by pulling an active-low power request. When the request is accepted, the block turns on the card charge pump and freezes the card voltage choice for the whole session. It then waits for the supply comparator to report that the card supply has settled. Only after that does it assert the active-low ready flag and open the reset and clock pass-through paths to the card.

While the session runs, the block watches for faults. Some checks run from the start of the session: card removal, and a supply that never settles. Others start only once ready is asserted: supply under-range, overtemperature, and a reset or clock line whose card-side level differs from the host-side level. These later faults are filtered by a timeout counted in clock cycles, so a short disturbance does not end the session. A fault that outlasts the timeout, or a card removal, moves the block to an alarm state. There the pump is off, the discharge clamp is on, and the active-low alarm flag is asserted. The alarm is left only when the host releases the power request.

All asynchronous inputs pass through a synchronizer chain before any decision is made. The analog comparators and the soft-start ramp are outside this block and appear only as digital inputs.

Top module: `card_pwr_supervisor`

## Requirements
- R1: After reset the block is idle: pump_en=0, ready_n=1, alarm_n=1, rst_pass_en=0, clk_pass_en=0, clamp_en=1.
- R2: In idle, a session is accepted when the synchronized request is low, vcc_drained is high and host_supply_ok is high. pump_en rises SYNC_STAGES+1 clock edges after the request input falls, clamp_en falls in the same cycle, and vsel_latched takes the value vsel_in had at acceptance (1 = high card voltage).
- R3: While a session is running, changes on vsel_in do not change vsel_latched.
- R4: ready_n falls SYNC_STAGES+1 edges after vcc_good rises during the ramp. rst_pass_en and clk_pass_en are 1 only while ready_n is 0.
- R5: The ramp has a time limit. If vcc_good never rises within RAMP_CYCLES cycles of ramping, the block enters alarm and ready_n never goes low.
- R6: When card_present goes low during a session, the block enters alarm SYNC_STAGES+1 edges later, without waiting for the fault timeout.
- R7: After ready, a fault on vcc_good low, over_temp high, or a host/card mismatch on reset or clock is filtered. If the fault lasts at most FAULT_CYCLES cycles, ready returns with no alarm. If the fault persists, alarm_n falls SYNC_STAGES+1+FAULT_CYCLES edges after the fault starts.
- R8: Before ready, over_temp and reset/clock mismatches are ignored.
- R9: In alarm: alarm_n=0, ready_n=1, pump_en=0, clamp_en=1 and the pass-through paths are closed. The alarm stays when the faults clear and is left only by releasing the request, which leads to idle with alarm_n=1.
- R10: While vcc_drained is low, a request does not start a session. The session starts once vcc_drained rises.
- R11: When host_supply_ok goes low, the block returns to idle SYNC_STAGES+1 edges later, from any state.
- R12: After reset or a host supply loss, the request must be seen high before a low request can start a new session.
- R13: Releasing the request during a session returns the block to idle: pump off, clamp on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req_n | input | 1 | Session request, active low |
| vsel_in | input | 1 | Card voltage choice, 1 = high |
| vcc_good | input | 1 | Card supply at its final value |
| vcc_drained | input | 1 | Card supply below the restart threshold |
| host_supply_ok | input | 1 | Host logic supply above its threshold |
| over_temp | input | 1 | Overtemperature flag |
| card_present | input | 1 | Raw card presence, 1 = present |
| host_rst | input | 1 | Host-side reset level |
| card_rst | input | 1 | Card-side reset level as observed |
| host_clk | input | 1 | Host-side clock level |
| card_clk | input | 1 | Card-side clock level as observed |
| pump_en | output | 1 | Charge pump enable |
| vsel_latched | output | 1 | Voltage choice frozen for the session |
| ready_n | output | 1 | Card supply ready, active low |
| alarm_n | output | 1 | Alarm, active low |
| rst_pass_en | output | 1 | Reset pass-through enable |
| clk_pass_en | output | 1 | Clock pass-through enable |
| clamp_en | output | 1 | Card supply discharge clamp enable |

## Verification
The bench builds the block with FAULT_CYCLES=8, RAMP_CYCLES=40 and SYNC_STAGES=2. With these values, the fault filter boundary can be probed exactly: a fault 8 cycles wide must not raise the alarm and one 9 cycles wide must. The ramp time limit can also be reached in a few dozen cycles. Random fault widths up to twice the timeout, drawn over the three late fault sources, are mixed with directed cases for removal, host supply loss, drain gating and alarm release.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RAMP  = 3'd1,
        ST_READY = 3'd2,
        ST_HOLD  = 3'd3,
        ST_ALARM = 3'd4
    } sup_state_e;

    // Synchronized view of every asynchronous input; req_n is the MSB.
    typedef struct packed {
        logic req_n;
        logic vsel;
        logic vcc_good;
        logic drained;
        logic host_ok;
        logic hot;
        logic present;
        logic host_rst;
        logic card_rst;
        logic host_clk;
        logic card_clk;
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);
    // Reset image of the synchronizer: request released, all else low.
    localparam logic [SENSE_W-1:0] SENSE_IDLE = {1'b1, {(SENSE_W-1){1'b0}}};

    typedef struct packed {
        logic removed;
        logic under;
        logic hot;
        logic mismatch;
    } fault_t;

    typedef struct packed {
        logic pump_en;
        logic ready_n;
        logic alarm_n;
        logic pass_en;
        logic clamp_en;
    } drive_t;

    function automatic drive_t drive_for(sup_state_e st);
        drive_t d;
        d = '{pump_en: 1'b0, ready_n: 1'b1, alarm_n: 1'b1, pass_en: 1'b0, clamp_en: 1'b1};
        case (st)
            ST_RAMP: begin
                d.pump_en  = 1'b1;
                d.clamp_en = 1'b0;
            end
            ST_READY, ST_HOLD: begin
                d.pump_en  = 1'b1;
                d.clamp_en = 1'b0;
                d.ready_n  = 1'b0;
                d.pass_en  = 1'b1;
            end
            ST_ALARM: begin
                d.alarm_n = 1'b0;
            end
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic in_session(sup_state_e st);
        return (st == ST_RAMP) || (st == ST_READY) || (st == ST_HOLD);
    endfunction

    function automatic logic late_fault(fault_t f);
        return f.under | f.hot | f.mismatch;
    endfunction

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

    logic [WIDTH-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[DEPTH-1];

    // The output only ever takes a value that sat in the previous stage.
    generate
        if (DEPTH > 1) begin : g_chk
            assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
                $past(!rst) |-> (q == $past(chain[DEPTH-2])));
        end
    endgenerate
endmodule

// File: rtl/cps_fault_eval.sv
module cps_fault_eval
    import cps_pkg::*;
(
    input  sense_t s,
    input  logic   late_en,
    output fault_t f
);
    logic rst_diff;
    logic clk_diff;

    always_comb begin
        rst_diff   = s.host_rst ^ s.card_rst;
        clk_diff   = s.host_clk ^ s.card_clk;
        f.removed  = ~s.present;
        f.under    = late_en & ~s.vcc_good;
        f.hot      = late_en & s.hot;
        f.mismatch = late_en & (rst_diff | clk_diff);
    end
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    output logic [WIDTH-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && (cnt != '1))
            cnt <= cnt + WIDTH'(1);
    end

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !clr && run && cnt != '1)) |-> (cnt == $past(cnt) + WIDTH'(1)));
endmodule

// File: rtl/card_pwr_supervisor.sv
module card_pwr_supervisor
    import cps_pkg::*;
#(
    parameter int FAULT_CYCLES = 16,
    parameter int RAMP_CYCLES  = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req_n,
    input  logic vsel_in,
    input  logic vcc_good,
    input  logic vcc_drained,
    input  logic host_supply_ok,
    input  logic over_temp,
    input  logic card_present,
    input  logic host_rst,
    input  logic card_rst,
    input  logic host_clk,
    input  logic card_clk,
    output logic pump_en,
    output logic vsel_latched,
    output logic ready_n,
    output logic alarm_n,
    output logic rst_pass_en,
    output logic clk_pass_en,
    output logic clamp_en
);
    localparam int LIM_MAX = (FAULT_CYCLES > RAMP_CYCLES) ? FAULT_CYCLES : RAMP_CYCLES;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] FAULT_LAST = CNT_W'(FAULT_CYCLES - 1);
    localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(RAMP_CYCLES - 1);

    sense_t             raw;
    sense_t             s;
    fault_t             f;
    sup_state_e         st_q, st_d;
    logic               armed_q;
    logic               vsel_q;
    logic               accept;
    logic               late_en;
    logic               late_any;
    logic [CNT_W-1:0]   cnt;
    drive_t             drv;

    assign raw = {pwr_req_n, vsel_in, vcc_good, vcc_drained, host_supply_ok,
                  over_temp, card_present, host_rst, card_rst, host_clk, card_clk};

    cps_sync #(
        .WIDTH   (SENSE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SENSE_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s)
    );

    assign late_en = (st_q == ST_READY) || (st_q == ST_HOLD);

    cps_fault_eval u_eval (
        .s       (s),
        .late_en (late_en),
        .f       (f)
    );

    assign late_any = late_fault(f);

    cps_timer #(.WIDTH(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (st_d != st_q),
        .run ((st_q == ST_RAMP) || (st_q == ST_HOLD)),
        .cnt (cnt)
    );

    // Next-state selection: host supply loss outranks everything, then
    // request release, then card removal, then staged faults.
    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (!s.host_ok) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (armed_q && !s.req_n && s.drained) begin
                        st_d   = ST_RAMP;
                        accept = 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (s.req_n)              st_d = ST_IDLE;
                    else if (f.removed)       st_d = ST_ALARM;
                    else if (s.vcc_good)      st_d = ST_READY;
                    else if (cnt == RAMP_LAST) st_d = ST_ALARM;
                end
                ST_READY: begin
                    if (s.req_n)        st_d = ST_IDLE;
                    else if (f.removed) st_d = ST_ALARM;
                    else if (late_any)  st_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (s.req_n)                st_d = ST_IDLE;
                    else if (f.removed)         st_d = ST_ALARM;
                    else if (!late_any)         st_d = ST_READY;
                    else if (cnt == FAULT_LAST) st_d = ST_ALARM;
                end
                ST_ALARM: begin
                    if (s.req_n) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            armed_q <= 1'b0;
            vsel_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept || !s.host_ok)
                armed_q <= 1'b0;
            else if (s.req_n)
                armed_q <= 1'b1;
            if (accept)
                vsel_q <= s.vsel;
        end
    end

    assign drv          = drive_for(st_q);
    assign pump_en      = drv.pump_en;
    assign ready_n      = drv.ready_n;
    assign alarm_n      = drv.alarm_n;
    assign rst_pass_en  = drv.pass_en;
    assign clk_pass_en  = drv.pass_en;
    assign clamp_en     = drv.clamp_en;
    assign vsel_latched = vsel_q;

    assert_vsel_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (in_session(st_q) && in_session($past(st_q))) |-> (vsel_q == $past(vsel_q)));

    assert_ready_entry_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_RAMP && st_q == ST_READY) |-> $past(s.vcc_good));

    assert_accept_drained_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_IDLE && st_q == ST_RAMP) |-> ($past(s.drained) && !$past(s.req_n)));

    assert_host_loss_R11: assert property (@(posedge clk) disable iff (rst)
        (!s.host_ok) |=> (st_q == ST_IDLE));

    assert_alarm_exit_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_ALARM && st_q != ST_ALARM) |-> ($past(s.req_n) || !$past(s.host_ok)));

    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> (cnt < CNT_W'(FAULT_CYCLES)));

    assert_removal_R6: assert property (@(posedge clk) disable iff (rst)
        (in_session(st_q) && f.removed && s.host_ok && !s.req_n) |=> (st_q == ST_ALARM));

    assert_rearm_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_IDLE && st_q == ST_RAMP) |-> $past(armed_q));
endmodule

// File: tb/sim_card_pwr_supervisor.sv
module sim_card_pwr_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int FC   = 8;
    localparam int RC   = 40;
    localparam int SS   = 2;
    localparam int LAT  = SS + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req_n = 1'b1, vsel_in = 1'b0, vcc_good = 1'b0, vcc_drained = 1'b1;
    logic host_supply_ok = 1'b1, over_temp = 1'b0, card_present = 1'b1;
    logic host_rst = 1'b0, card_rst = 1'b0, host_clk = 1'b0, card_clk = 1'b0;
    logic pump_en, vsel_latched, ready_n, alarm_n, rst_pass_en, clk_pass_en, clamp_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_pwr_supervisor #(
        .FAULT_CYCLES (FC),
        .RAMP_CYCLES  (RC),
        .SYNC_STAGES  (SS)
    ) u0 (
        .clk(clk), .rst(rst), .pwr_req_n(pwr_req_n), .vsel_in(vsel_in),
        .vcc_good(vcc_good), .vcc_drained(vcc_drained), .host_supply_ok(host_supply_ok),
        .over_temp(over_temp), .card_present(card_present), .host_rst(host_rst),
        .card_rst(card_rst), .host_clk(host_clk), .card_clk(card_clk),
        .pump_en(pump_en), .vsel_latched(vsel_latched), .ready_n(ready_n),
        .alarm_n(alarm_n), .rst_pass_en(rst_pass_en), .clk_pass_en(clk_pass_en),
        .clamp_en(clamp_en)
    );

    function automatic bit expect_alarm(int width);
        return width > FC;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_outputs(string req);
        chk(req, "pump_en", pump_en, 0);
        chk(req, "ready_n", ready_n, 1);
        chk(req, "clamp_en", clamp_en, 1);
        chk(req, "rst_pass_en", rst_pass_en, 0);
    endtask

    task automatic bring_up(bit vs);
        pwr_req_n = 1'b1; vcc_good = 1'b0; vcc_drained = 1'b1; over_temp = 1'b0;
        card_present = 1'b1; card_rst = host_rst; card_clk = host_clk;
        cyc(LAT + 2);
        vsel_in = vs;
        pwr_req_n = 1'b0;
        cyc(LAT - 1);
        chk("R2", "pump_en before latency", pump_en, 0);
        cyc(1);
        chk("R2", "pump_en", pump_en, 1);
        chk("R2", "clamp_en", clamp_en, 0);
        chk("R2", "vsel_latched", vsel_latched, vs);
        vsel_in = ~vs;
        vcc_drained = 1'b0;
        vcc_good = 1'b1;
        cyc(LAT - 1);
        chk("R4", "ready_n before latency", ready_n, 1);
        chk("R4", "clk_pass_en before ready", clk_pass_en, 0);
        cyc(1);
        chk("R4", "ready_n", ready_n, 0);
        chk("R4", "rst_pass_en", rst_pass_en, 1);
        chk("R4", "clk_pass_en", clk_pass_en, 1);
        chk("R3", "vsel_latched after vsel_in change", vsel_latched, vs);
    endtask

    task automatic release_req();
        pwr_req_n = 1'b1;
        cyc(LAT);
        chk("R13", "alarm_n after release", alarm_n, 1);
        idle_outputs("R13");
        vcc_good = 1'b0;
        vcc_drained = 1'b1;
    endtask

    // src 0: supply under-range, 1: overtemperature, 2: reset mismatch, 3: clock mismatch
    task automatic set_fault(int src, bit on);
        case (src)
            0: vcc_good  = ~on;
            1: over_temp = on;
            2: card_rst  = on ? ~host_rst : host_rst;
            default: card_clk = on ? ~host_clk : host_clk;
        endcase
    endtask

    task automatic glitch(int src, int width);
        bit saw = 1'b0;
        set_fault(src, 1'b1);
        for (int k = 0; k < width; k++) begin
            @(negedge clk);
            if (!alarm_n) saw = 1'b1;
        end
        set_fault(src, 1'b0);
        for (int k = 0; k < FC + LAT + 4; k++) begin
            @(negedge clk);
            if (!alarm_n) saw = 1'b1;
        end
        chk("R7", $sformatf("alarm seen src=%0d width=%0d", src, width), saw, expect_alarm(width));
        chk("R7", "ready_n after glitch", ready_n, expect_alarm(width) ? 1 : 0);
        if (expect_alarm(width)) begin
            release_req();
            bring_up(1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog R1..none actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        idle_outputs("R1");
        chk("R1", "alarm_n", alarm_n, 1);
        chk("R1", "clk_pass_en", clk_pass_en, 0);

        // R2/R3/R4 with both voltage choices, R13 release
        bring_up(1'b1);
        release_req();
        bring_up(1'b0);

        // R8: late checks ignored during the ramp
        release_req();
        vcc_drained = 1'b1;
        pwr_req_n = 1'b0;
        cyc(LAT);
        vcc_drained = 1'b0;
        over_temp = 1'b1; card_clk = ~host_clk; card_rst = ~host_rst;
        cyc(RC - 10);
        chk("R8", "alarm_n during ramp with late faults", alarm_n, 1);
        chk("R8", "pump_en during ramp", pump_en, 1);
        over_temp = 1'b0; card_clk = host_clk; card_rst = host_rst;
        release_req();

        // R5: ramp time limit
        pwr_req_n = 1'b0;
        cyc(LAT);
        vcc_drained = 1'b0;
        begin
            bit saw_ready = 1'b0;
            for (int k = 0; k < RC - 1; k++) begin
                @(negedge clk);
                if (!ready_n) saw_ready = 1'b1;
            end
            chk("R5", "alarm_n before limit", alarm_n, 1);
            cyc(1);
            chk("R5", "alarm_n at limit", alarm_n, 0);
            chk("R5", "ready never low", saw_ready, 0);
        end

        // R9: alarm sticky and its outputs
        cyc(10);
        chk("R9", "alarm_n holds", alarm_n, 0);
        chk("R9", "ready_n", ready_n, 1);
        chk("R9", "pump_en", pump_en, 0);
        chk("R9", "clamp_en", clamp_en, 1);
        chk("R9", "rst_pass_en", rst_pass_en, 0);
        release_req();

        // R6: removal after ready
        bring_up(1'b1);
        card_present = 1'b0;
        cyc(LAT - 1);
        chk("R6", "alarm_n before latency", alarm_n, 1);
        cyc(1);
        chk("R6", "alarm_n after removal", alarm_n, 0);
        chk("R6", "ready_n after removal", ready_n, 1);
        release_req();
        card_present = 1'b1;

        // R6: removal during ramp
        pwr_req_n = 1'b0;
        cyc(LAT);
        vcc_drained = 1'b0;
        card_present = 1'b0;
        cyc(LAT);
        chk("R6", "alarm_n removal in ramp", alarm_n, 0);
        release_req();
        card_present = 1'b1;

        // R7: persistent fault exact timing
        bring_up(1'b0);
        over_temp = 1'b1;
        cyc(LAT + FC - 1);
        chk("R7", "alarm_n one cycle before timeout", alarm_n, 1);
        chk("R7", "ready_n still low in hold", ready_n, 0);
        cyc(1);
        chk("R7", "alarm_n at timeout", alarm_n, 0);
        over_temp = 1'b0;
        release_req();

        // R7 boundary: exactly FC no alarm, FC+1 alarm
        bring_up(1'b1);
        glitch(0, FC);
        glitch(2, FC + 1);
        glitch(3, 1);

        // R10: drain gating
        release_req();
        vcc_drained = 1'b0;
        pwr_req_n = 1'b0;
        cyc(12);
        chk("R10", "pump_en while not drained", pump_en, 0);
        vcc_drained = 1'b1;
        cyc(LAT);
        chk("R10", "pump_en after drain", pump_en, 1);
        vcc_drained = 1'b0;
        vcc_good = 1'b1;
        cyc(LAT);

        // R11 and R12: host supply loss with request still low
        host_supply_ok = 1'b0;
        cyc(LAT);
        idle_outputs("R11");
        host_supply_ok = 1'b1;
        vcc_good = 1'b0;
        vcc_drained = 1'b1;
        cyc(12);
        chk("R12", "no session without release", pump_en, 0);
        pwr_req_n = 1'b1;
        cyc(LAT + 1);
        pwr_req_n = 1'b0;
        cyc(LAT);
        chk("R12", "session after release", pump_en, 1);

        // R11 from alarm
        vcc_drained = 1'b0;
        card_present = 1'b0;
        cyc(LAT);
        chk("R11", "alarm before host loss", alarm_n, 0);
        card_present = 1'b1;
        host_supply_ok = 1'b0;
        cyc(LAT);
        chk("R11", "alarm_n cleared by host loss", alarm_n, 1);
        idle_outputs("R11");
        host_supply_ok = 1'b1;

        // Random fault widths on the late sources
        bring_up(1'b0);
        for (int i = 0; i < 14; i++) begin
            int w   = $urandom_range(2 * FC, 1);
            int src = $urandom_range(3, 0);
            glitch(src, w);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule